// File: doc/BRIEF.md
# Sixteen-bit ALU with registered status flags

This block is the arithmetic core of a small processor datapath. It takes two 16-bit operands, a 4-bit operation code, a carry-in and a size select. From these it computes addition, subtraction, single-position shifts and bitwise logic, all in two's complement. The result is combinational. Five status flags are held in registers: Carry, Zero, Negative, Overflow and Digit Carry. Each flag has its own update enable, and a common strobe qualifies all five writes.

The size select chooses byte mode or word mode. In byte mode only the low eight bits take part, and every flag is taken from the byte boundaries instead of the word boundaries. Subtraction uses active-high "no borrow" semantics, so after a subtract, Carry and Digit Carry read 1 when nothing was borrowed. Each operation class changes only the flags it defines. All other flags keep their stored value.

Top module: `alu16_status`

## Requirements
- R1: Opcode 0 (add) gives opA+opB. Opcode 1 (add with carry) gives opA+opB+carryIn. Carry is the carry out of the active width.
- R2: Opcode 2 (subtract) gives opA-opB. Opcode 3 (subtract with borrow) gives opA-opB-(1-carryIn). Carry is 1 when no borrow occurred.
- R3: For add and subtract, Overflow is 1 when the signed result cannot be represented in the active width. This covers two operands of the same sign producing a sum of the other sign, and the matching rule for subtract.
- R4: Digit Carry is the carry (subtract: no-borrow) out of bit 3 in byte mode and out of bit 7 in word mode.
- R5: With byteMode=1, result[15:8] is 0. Carry, Negative and Overflow come from bit 7, and Zero tests result[7:0] only.
- R6: Zero is 1 exactly when the active-width result is all zeros. Negative equals the top bit of the active width.
- R7: Opcodes 4, 5 and 6 (AND, OR, XOR) update only Zero and Negative. Unassigned opcodes (7, 11 to 15) pass opA through and change no flag.
- R8: Opcodes 8, 9 and 10 shift opA by one position: left, logical right and arithmetic right. The bit shifted out goes to Carry, arithmetic right keeps the sign bit, and Overflow and Digit Carry are unchanged.
- R9: A flag changes only on a rising clock edge where flagStrobe is 1 and its bit of updEn is 1. The updEn bit order is 0 = Carry, 1 = Zero, 2 = Negative, 3 = Overflow, 4 = Digit Carry. Otherwise the flag holds its value.
- R10: An active-low reset clears all five flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| opA | input | 16 | First operand, also the shift source |
| opB | input | 16 | Second operand |
| opCode | input | 4 | Operation select |
| carryIn | input | 1 | Carry / not-borrow input for opcodes 1 and 3 |
| byteMode | input | 1 | 1 selects 8-bit operation |
| flagStrobe | input | 1 | Qualifies all flag writes |
| updEn | input | 5 | Per-flag write enable |
| result | output | 16 | Combinational result |
| flagC | output | 1 | Carry / no-borrow flag |
| flagZ | output | 1 | Zero flag |
| flagN | output | 1 | Negative flag |
| flagV | output | 1 | Overflow flag |
| flagDC | output | 1 | Digit carry / digit no-borrow flag |

## Verification
The result is combinational, so a wrong adder segment, shift path or byte-lane mask shows on `result` in the same cycle as the stimulus. Flag errors appear one clock edge later, on the flag outputs. A write enable decoded wrongly for one operation class is the hardest fault to see. It shows only when the flag that should have held has a stored value different from the new computed one. For that reason the stimulus first drives flags to mixed values and then runs logic, shift and strobe-low operations on top of them.

// File: rtl/alu16_pkg.sv
`timescale 1ns/100ps
package alu16_pkg;

  localparam int NUM_FLAGS = 5;
  localparam int FL_C  = 0;
  localparam int FL_Z  = 1;
  localparam int FL_N  = 2;
  localparam int FL_V  = 3;
  localparam int FL_DC = 4;

  localparam logic [3:0] OP_ADD = 4'd0;
  localparam logic [3:0] OP_ADC = 4'd1;
  localparam logic [3:0] OP_SUB = 4'd2;
  localparam logic [3:0] OP_SBB = 4'd3;
  localparam logic [3:0] OP_AND = 4'd4;
  localparam logic [3:0] OP_OR  = 4'd5;
  localparam logic [3:0] OP_XOR = 4'd6;
  localparam logic [3:0] OP_SHL = 4'd8;
  localparam logic [3:0] OP_SHR = 4'd9;
  localparam logic [3:0] OP_SAR = 4'd10;

  typedef enum logic [1:0] {RES_ADDER, RES_LOGIC, RES_SHIFT, RES_PASS} resSelE;
  typedef enum logic [1:0] {LG_AND, LG_OR, LG_XOR} logicFnE;
  typedef enum logic [1:0] {SH_LEFT, SH_RIGHT, SH_ARITH} shiftFnE;

  typedef struct packed {
    logic                 invB;
    logic                 useCin;
    logic                 cinConst;
    resSelE               resSel;
    logicFnE              logicFn;
    shiftFnE              shiftFn;
    logic [NUM_FLAGS-1:0] flagWe;
  } aluCtrlS;

endpackage

// File: rtl/alu16_ctrl.sv
`timescale 1ns/100ps
module alu16_ctrl
  import alu16_pkg::*;
(
  input  logic [3:0]           opCode,
  input  logic                 flagStrobe,
  input  logic [NUM_FLAGS-1:0] updEn,
  output aluCtrlS              ctrl
);

  localparam logic [NUM_FLAGS-1:0] AFF_ALL   = '1;
  localparam logic [NUM_FLAGS-1:0] AFF_LOGIC = NUM_FLAGS'((1 << FL_Z) | (1 << FL_N));
  localparam logic [NUM_FLAGS-1:0] AFF_SHIFT = NUM_FLAGS'((1 << FL_C) | (1 << FL_Z) | (1 << FL_N));

  logic [NUM_FLAGS-1:0] affect;

  always_comb begin
    ctrl        = '0;
    ctrl.resSel = RES_PASS;
    affect      = '0;
    case (opCode)
      OP_ADD: begin ctrl.resSel = RES_ADDER; affect = AFF_ALL; end
      OP_ADC: begin ctrl.resSel = RES_ADDER; ctrl.useCin = 1'b1; affect = AFF_ALL; end
      OP_SUB: begin
        ctrl.resSel = RES_ADDER; ctrl.invB = 1'b1; ctrl.cinConst = 1'b1; affect = AFF_ALL;
      end
      OP_SBB: begin
        ctrl.resSel = RES_ADDER; ctrl.invB = 1'b1; ctrl.useCin = 1'b1; affect = AFF_ALL;
      end
      OP_AND: begin ctrl.resSel = RES_LOGIC; ctrl.logicFn = LG_AND; affect = AFF_LOGIC; end
      OP_OR:  begin ctrl.resSel = RES_LOGIC; ctrl.logicFn = LG_OR;  affect = AFF_LOGIC; end
      OP_XOR: begin ctrl.resSel = RES_LOGIC; ctrl.logicFn = LG_XOR; affect = AFF_LOGIC; end
      OP_SHL: begin ctrl.resSel = RES_SHIFT; ctrl.shiftFn = SH_LEFT;  affect = AFF_SHIFT; end
      OP_SHR: begin ctrl.resSel = RES_SHIFT; ctrl.shiftFn = SH_RIGHT; affect = AFF_SHIFT; end
      OP_SAR: begin ctrl.resSel = RES_SHIFT; ctrl.shiftFn = SH_ARITH; affect = AFF_SHIFT; end
      default: affect = '0;
    endcase
    ctrl.flagWe = updEn & affect & {NUM_FLAGS{flagStrobe}};
  end

endmodule

// File: rtl/alu16_datapath.sv
`timescale 1ns/100ps
module alu16_datapath
  import alu16_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [WIDTH-1:0]     opA,
  input  logic [WIDTH-1:0]     opB,
  input  logic                 carryIn,
  input  logic                 byteMode,
  input  aluCtrlS              ctrl,
  output logic [WIDTH-1:0]     result,
  output logic [NUM_FLAGS-1:0] flags
);

  localparam int HALF  = WIDTH / 2;
  localparam int QUART = WIDTH / 4;
  localparam int UPPER = WIDTH - HALF;
  localparam int MID   = HALF - QUART;

  logic [WIDTH-1:0]     bEff;
  logic                 cinEff;
  logic [QUART:0]       sumLo;
  logic [MID:0]         sumMid;
  logic [UPPER:0]       sumHi;
  logic [WIDTH-1:0]     addRes;
  logic [WIDTH-1:0]     logicRes;
  logic [WIDTH-1:0]     shRes;
  logic                 shCarry;
  logic [WIDTH-1:0]     rawRes;
  logic                 signA, signB, signR;
  logic [NUM_FLAGS-1:0] nextFlags;

  assign bEff   = ctrl.invB ? ~opB : opB;
  assign cinEff = ctrl.useCin ? carryIn : ctrl.cinConst;

  // Adder split at the digit and byte boundaries so their carries are explicit
  assign sumLo  = {1'b0, opA[QUART-1:0]} + {1'b0, bEff[QUART-1:0]} + {{QUART{1'b0}}, cinEff};
  assign sumMid = {1'b0, opA[HALF-1:QUART]} + {1'b0, bEff[HALF-1:QUART]} + {{MID{1'b0}}, sumLo[QUART]};
  assign sumHi  = {1'b0, opA[WIDTH-1:HALF]} + {1'b0, bEff[WIDTH-1:HALF]} + {{UPPER{1'b0}}, sumMid[MID]};
  assign addRes = {sumHi[UPPER-1:0], sumMid[MID-1:0], sumLo[QUART-1:0]};

  always_comb begin
    case (ctrl.logicFn)
      LG_OR:   logicRes = opA | opB;
      LG_XOR:  logicRes = opA ^ opB;
      default: logicRes = opA & opB;
    endcase
  end

  always_comb begin
    case (ctrl.shiftFn)
      SH_LEFT:  shRes = byteMode ? {{UPPER{1'b0}}, opA[HALF-2:0], 1'b0} : {opA[WIDTH-2:0], 1'b0};
      SH_RIGHT: shRes = byteMode ? {{UPPER{1'b0}}, 1'b0, opA[HALF-1:1]} : {1'b0, opA[WIDTH-1:1]};
      default:  shRes = byteMode ? {{UPPER{1'b0}}, opA[HALF-1], opA[HALF-1:1]}
                                 : {opA[WIDTH-1], opA[WIDTH-1:1]};
    endcase
    if (ctrl.shiftFn == SH_LEFT) shCarry = byteMode ? opA[HALF-1] : opA[WIDTH-1];
    else                         shCarry = opA[0];
  end

  always_comb begin
    case (ctrl.resSel)
      RES_ADDER: rawRes = addRes;
      RES_LOGIC: rawRes = logicRes;
      RES_SHIFT: rawRes = shRes;
      default:   rawRes = opA;
    endcase
  end

  assign result = byteMode ? {{UPPER{1'b0}}, rawRes[HALF-1:0]} : rawRes;

  assign signA = byteMode ? opA[HALF-1]    : opA[WIDTH-1];
  assign signB = byteMode ? bEff[HALF-1]   : bEff[WIDTH-1];
  assign signR = byteMode ? result[HALF-1] : result[WIDTH-1];

  always_comb begin
    nextFlags[FL_C]  = (ctrl.resSel == RES_SHIFT) ? shCarry
                     : (byteMode ? sumMid[MID] : sumHi[UPPER]);
    nextFlags[FL_Z]  = byteMode ? (result[HALF-1:0] == '0) : (result == '0);
    nextFlags[FL_N]  = signR;
    nextFlags[FL_V]  = (signA == signB) && (signR != signA);
    nextFlags[FL_DC] = byteMode ? sumLo[QUART] : sumMid[MID];
  end

  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                flags[i] <= 1'b0;
      else if (ctrl.flagWe[i])  flags[i] <= nextFlags[i];
    end
  end

endmodule

// File: rtl/alu16_status.sv
`timescale 1ns/100ps
module alu16_status
  import alu16_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [WIDTH-1:0]     opA,
  input  logic [WIDTH-1:0]     opB,
  input  logic [3:0]           opCode,
  input  logic                 carryIn,
  input  logic                 byteMode,
  input  logic                 flagStrobe,
  input  logic [NUM_FLAGS-1:0] updEn,
  output logic [WIDTH-1:0]     result,
  output logic                 flagC,
  output logic                 flagZ,
  output logic                 flagN,
  output logic                 flagV,
  output logic                 flagDC
);

  aluCtrlS              ctrl;
  logic [NUM_FLAGS-1:0] flags;

  alu16_ctrl u_ctrl (
    .opCode     (opCode),
    .flagStrobe (flagStrobe),
    .updEn      (updEn),
    .ctrl       (ctrl)
  );

  alu16_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .opA      (opA),
    .opB      (opB),
    .carryIn  (carryIn),
    .byteMode (byteMode),
    .ctrl     (ctrl),
    .result   (result),
    .flags    (flags)
  );

  assign flagC  = flags[FL_C];
  assign flagZ  = flags[FL_Z];
  assign flagN  = flags[FL_N];
  assign flagV  = flags[FL_V];
  assign flagDC = flags[FL_DC];

endmodule

// File: rtl/alu16_status_chk.sv
`timescale 1ns/100ps
module alu16_status_chk
  import alu16_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [WIDTH-1:0]     opA,
  input logic [WIDTH-1:0]     opB,
  input logic [3:0]           opCode,
  input logic                 byteMode,
  input logic                 flagStrobe,
  input logic [NUM_FLAGS-1:0] updEn,
  input logic [WIDTH-1:0]     result,
  input logic                 flagC,
  input logic                 flagZ,
  input logic                 flagN,
  input logic                 flagV,
  input logic                 flagDC
);

  localparam int HALF = WIDTH / 2;

  // R9
  strobe_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !flagStrobe |=> $stable({flagC, flagZ, flagN, flagV, flagDC}));

  // R7
  logic_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (flagStrobe && (opCode == OP_AND || opCode == OP_OR || opCode == OP_XOR))
      |=> $stable({flagC, flagV, flagDC}));

  // R5
  byte_upper_chk: assert property (@(posedge clk) disable iff (!rstN)
    byteMode |-> (result[WIDTH-1:HALF] == '0));

  // R6
  zero_word_chk: assert property (@(posedge clk) disable iff (!rstN)
    (flagStrobe && updEn[FL_Z] && !byteMode && opCode != 4'd7 && opCode < 4'd11)
      |=> (flagZ == ($past(result) == '0)));

  // R8
  sar_sign_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opCode == OP_SAR && !byteMode) |-> (result[WIDTH-1] == opA[WIDTH-1]));

  // R2
  sub_borrow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opCode == OP_SUB && !byteMode && flagStrobe && updEn[FL_C])
      |=> (flagC == ($past(opA) >= $past(opB))));

endmodule

bind alu16_status alu16_status_chk #(.WIDTH(WIDTH)) u_status_chk (
  .clk        (clk),
  .rstN       (rstN),
  .opA        (opA),
  .opB        (opB),
  .opCode     (opCode),
  .byteMode   (byteMode),
  .flagStrobe (flagStrobe),
  .updEn      (updEn),
  .result     (result),
  .flagC      (flagC),
  .flagZ      (flagZ),
  .flagN      (flagN),
  .flagV      (flagV),
  .flagDC     (flagDC)
);

// File: tb/tb_alu16_status.sv
`timescale 1ns/100ps
module tb_alu16_status;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] opA = '0;
  logic [15:0] opB = '0;
  logic [3:0]  opCode = '0;
  logic        carryIn = 1'b0;
  logic        byteMode = 1'b0;
  logic        flagStrobe = 1'b0;
  logic [4:0]  updEn = '0;
  logic [15:0] result;
  logic        flagC, flagZ, flagN, flagV, flagDC;

  int  nChecks = 0;
  int  nFails = 0;
  bit  finished = 1'b0;

  typedef struct {
    logic [15:0] res;
    logic [4:0]  fl;
    string       tag;
  } itemT;

  itemT        sbq[$];
  logic [4:0]  modelFlags = '0;

  always #2.5 clk = ~clk;

  alu16_status dut (
    .clk(clk), .rstN(rstN), .opA(opA), .opB(opB), .opCode(opCode),
    .carryIn(carryIn), .byteMode(byteMode), .flagStrobe(flagStrobe),
    .updEn(updEn), .result(result), .flagC(flagC), .flagZ(flagZ),
    .flagN(flagN), .flagV(flagV), .flagDC(flagDC)
  );

  function automatic void refModel(input logic [3:0] op, input logic [15:0] a, b,
                                   input logic cin, bm,
                                   output logic [15:0] r, output logic [4:0] nf,
                                   output logic [4:0] aff);
    int w, m, hm, ua, ub, sa, sb, s, sv, ci, rr;
    w  = bm ? 8 : 16;
    m  = (1 << w) - 1;
    hm = (1 << (w / 2)) - 1;
    ua = int'(a) & m;
    ub = int'(b) & m;
    sa = (ua >= (1 << (w - 1))) ? ua - (1 << w) : ua;
    sb = (ub >= (1 << (w - 1))) ? ub - (1 << w) : ub;
    nf = '0; aff = '0; rr = ua;
    case (op)
      4'd0, 4'd1: begin
        ci = (op == 4'd1 && cin) ? 1 : 0;
        s = ua + ub + ci; rr = s & m;
        nf[0] = s > m;
        nf[4] = ((ua & hm) + (ub & hm) + ci) > hm;
        sv = sa + sb + ci;
        nf[3] = (sv >= (1 << (w - 1))) || (sv < -(1 << (w - 1)));
        aff = 5'b11111;
      end
      4'd2, 4'd3: begin
        ci = (op == 4'd3 && !cin) ? 1 : 0;
        s = ua - ub - ci; rr = s & m;
        nf[0] = s >= 0;
        nf[4] = ((ua & hm) - (ub & hm) - ci) >= 0;
        sv = sa - sb - ci;
        nf[3] = (sv >= (1 << (w - 1))) || (sv < -(1 << (w - 1)));
        aff = 5'b11111;
      end
      4'd4: begin rr = ua & ub; aff = 5'b00110; end
      4'd5: begin rr = ua | ub; aff = 5'b00110; end
      4'd6: begin rr = ua ^ ub; aff = 5'b00110; end
      4'd8: begin rr = (ua << 1) & m; nf[0] = ((ua >> (w - 1)) & 1) != 0; aff = 5'b00111; end
      4'd9: begin rr = ua >> 1; nf[0] = (ua & 1) != 0; aff = 5'b00111; end
      4'd10: begin
        rr = (ua >> 1) | (ua & (1 << (w - 1)));
        nf[0] = (ua & 1) != 0; aff = 5'b00111;
      end
      default: aff = '0;
    endcase
    nf[1] = (rr == 0);
    nf[2] = ((rr >> (w - 1)) & 1) != 0;
    r = rr[15:0];
  endfunction

  // Driver: applies one operation at the falling edge and queues its expectation
  task automatic drive(input logic [3:0] op, input logic [15:0] a, b,
                       input logic cin, bm, stb, input logic [4:0] en, input string tag);
    logic [15:0] r;
    logic [4:0]  nf, aff;
    itemT        it;
    @(negedge clk);
    opCode = op; opA = a; opB = b; carryIn = cin; byteMode = bm;
    flagStrobe = stb; updEn = en;
    refModel(op, a, b, cin, bm, r, nf, aff);
    for (int i = 0; i < 5; i++)
      if (stb && en[i] && aff[i]) modelFlags[i] = nf[i];
    it.res = r; it.fl = modelFlags; it.tag = tag;
    sbq.push_back(it);
  endtask

  // Monitor: one clock edge after driving, result and flags are both settled
  initial begin
    itemT it;
    logic [4:0] got;
    forever begin
      @(posedge clk);
      #1;
      if (sbq.size() > 0) begin
        it = sbq.pop_front();
        got = {flagDC, flagV, flagN, flagZ, flagC};
        nChecks++;
        if (result !== it.res) begin
          nFails++;
          $display("FAIL %s result: actual %h expected %h", it.tag, result, it.res);
        end
        nChecks++;
        if (got !== it.fl) begin
          nFails++;
          $display("FAIL %s flags{DC,V,N,Z,C}: actual %b expected %b", it.tag, got, it.fl);
        end
      end
    end
  end

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    logic [3:0] opList [10];
    opList = '{4'd0, 4'd1, 4'd2, 4'd3, 4'd4, 4'd5, 4'd6, 4'd8, 4'd9, 4'd10};
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R10: flags cleared by reset
    nChecks++;
    if ({flagDC, flagV, flagN, flagZ, flagC} !== 5'b0) begin
      nFails++;
      $display("FAIL R10 reset flags: actual %b expected 00000",
               {flagDC, flagV, flagN, flagZ, flagC});
    end

    drive(4'd0, 16'hFFFF, 16'h0001, 1'b0, 1'b0, 1'b1, 5'h1F, "R1 add wrap");
    drive(4'd1, 16'h1234, 16'h0001, 1'b1, 1'b0, 1'b1, 5'h1F, "R1 adc cin");
    drive(4'd2, 16'h0005, 16'h0003, 1'b0, 1'b0, 1'b1, 5'h1F, "R2 sub no borrow");
    drive(4'd2, 16'h0003, 16'h0005, 1'b0, 1'b0, 1'b1, 5'h1F, "R2 sub borrow");
    drive(4'd3, 16'h0010, 16'h0010, 1'b0, 1'b0, 1'b1, 5'h1F, "R2 sbb borrow in");
    drive(4'd0, 16'h7FFF, 16'h0001, 1'b0, 1'b0, 1'b1, 5'h1F, "R3 add overflow");
    drive(4'd2, 16'h8000, 16'h0001, 1'b0, 1'b0, 1'b1, 5'h1F, "R3 sub overflow");
    drive(4'd0, 16'h000F, 16'h0001, 1'b0, 1'b1, 1'b1, 5'h1F, "R4 byte digit carry");
    drive(4'd0, 16'h00FF, 16'h0001, 1'b0, 1'b0, 1'b1, 5'h1F, "R4 word digit carry");
    drive(4'd2, 16'h0010, 16'h0001, 1'b0, 1'b1, 1'b1, 5'h1F, "R4 byte digit borrow");
    drive(4'd0, 16'h12FF, 16'h3401, 1'b0, 1'b1, 1'b1, 5'h1F, "R5 byte wrap");
    drive(4'd0, 16'h107F, 16'h2001, 1'b0, 1'b1, 1'b1, 5'h1F, "R5 byte overflow");
    drive(4'd6, 16'hA5A5, 16'hA5A5, 1'b0, 1'b0, 1'b1, 5'h1F, "R6 zero word");
    drive(4'd5, 16'h8000, 16'h0001, 1'b0, 1'b0, 1'b1, 5'h1F, "R6 negative word");
    drive(4'd0, 16'h7FFF, 16'h7FFF, 1'b0, 1'b0, 1'b1, 5'h1F, "R7 preset flags");
    drive(4'd4, 16'h00F0, 16'h0F00, 1'b0, 1'b0, 1'b1, 5'h1F, "R7 and keeps C V DC");
    drive(4'd12, 16'hBEEF, 16'h0000, 1'b0, 1'b0, 1'b1, 5'h1F, "R7 unassigned opcode");
    drive(4'd8, 16'h8001, 16'h0000, 1'b0, 1'b0, 1'b1, 5'h1F, "R8 shl carry");
    drive(4'd10, 16'h8002, 16'h0000, 1'b0, 1'b0, 1'b1, 5'h1F, "R8 sar sign");
    drive(4'd9, 16'h0081, 16'h0000, 1'b0, 1'b1, 1'b1, 5'h1F, "R8 byte shr carry");
    drive(4'd10, 16'h0081, 16'h0000, 1'b0, 1'b1, 1'b1, 5'h1F, "R8 byte sar sign");
    drive(4'd0, 16'hFFFF, 16'hFFFF, 1'b0, 1'b0, 1'b0, 5'h1F, "R9 strobe low");
    drive(4'd0, 16'h0000, 16'h0000, 1'b0, 1'b0, 1'b1, 5'b00010, "R9 zero only");
    drive(4'd0, 16'hFFFF, 16'h0001, 1'b0, 1'b0, 1'b1, 5'b00001, "R9 carry only");

    for (int k = 0; k < 400; k++) begin
      drive(opList[$urandom_range(9)], 16'($urandom), 16'($urandom), 1'($urandom),
            1'($urandom), ($urandom_range(3) != 0), 5'($urandom), "R1 R2 R3 R4 R5 R6 R8 R9 random");
    end

    while (sbq.size() > 0) @(posedge clk);
    repeat (2) @(posedge clk);
    finishRun();
  end

endmodule